// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block resolves the operand address of an indexed instruction in an 8-bit processor core. The sequencer pulses `start` with the postbyte, the four pointer registers, the two accumulators and the address of the byte after the postbyte. The block then works out the address and returns it with a one-cycle `done` strobe.

It decodes the postbyte and pulls any offset bytes from the instruction stream through a byte-wide read port. It adds a sign-extended offset to a pointer register or to the program counter. When the indirect bit is set, it reads a two-byte pointer, high byte first, and returns that pointer as the final address.

Along with the address it returns:
- the write-back value for the auto-increment and auto-decrement forms;
- the number of offset bytes consumed;
- the extra cycle cost of the form;
- a flag for encodings that have no meaning.

The memory port uses a request/valid handshake, so a slow memory can stretch any read by wait states.

Top module: `idx_ea_gen`

## Requirements
- R1: With postbyte bit 7 at 0, the address is the selected pointer plus bits 4:0 read as a signed value from -16 to +15. No offset byte is fetched, there is no write-back, the form is never indirect and the extra cycle count is 1.
- R2: Postbyte bits 6:5 pick the pointer register: 00 picks X, 01 picks Y, 10 picks U and 11 picks S. `wb_sel` reports the same code.
- R3: Mode 0000 (increment by 1) and mode 0001 (increment by 2) address the pointer's old value and write back the old value plus 1 or plus 2. Mode 0010 (decrement by 1) and mode 0011 (decrement by 2) subtract 1 or 2 first, and use that result both as the address and as the write-back value. All arithmetic wraps at 16 bits.
- R4: Mode 0110 adds sign-extended A and mode 0101 adds sign-extended B. Mode 1011 adds the 16-bit value A:B, with A as the high byte. None of these three writes back.
- R5: Mode 1000 fetches one offset byte at `pc_next` and sign-extends it. Mode 1001 fetches two offset bytes at `pc_next` and `pc_next+1`, high byte first. Either offset is added to the pointer modulo 2^16, with no write-back.
- R6: Mode 1100 (one offset byte) and mode 1101 (two offset bytes) add their offset to `pc_next` plus the number of offset bytes. Bits 6:5 have no effect on the result.
- R7: With bit 7 at 1 and bit 4 at 1, the computed address is read as a pointer (high byte at the address, low byte at the address plus 1), and that pointer is the reported address. A write-back still happens for modes 0001 and 0011.
- R8: Mode 1111 with bit 4 set fetches a two-byte absolute address after the postbyte, high byte first, and then reads the final pointer from that address.
- R9: The extra cycle count for the direct and indirect variants of each form is:
  - zero offset (0100): 0 / 3
  - A or B offset: 1 / 4
  - 8-bit constant offset: 1 / 4
  - 16-bit constant offset: 4 / 7
  - D offset: 4 / 7
  - increment or decrement by 1: 2 / not allowed
  - increment or decrement by 2: 3 / 6
  - PC plus 8-bit offset: 1 / 4
  - PC plus 16-bit offset: 5 / 8
  - absolute address (1111): indirect only, 5

  `extra_bytes` is 0, 1 or 2, matching the offset bytes fetched.
- R10: The following encodings raise `illegal` at `done`:
  - codes 0111, 1010 and 1110;
  - code 0000 or 0010 with bit 4 set;
  - code 1111 with bit 4 clear.

  For these, no memory request is made, `wb_en` stays low, and `extra_bytes` and `extra_cycles` read 0.
- R11: After reset `done` and `mem_req` are low. `mem_req` and `mem_addr` hold steady until a cycle with `mem_valid` high takes the byte, and every request ends in exactly one single-cycle `done` pulse, whatever the wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a request; inputs below are captured in this cycle |
| postbyte | input | 8 | Indexed-mode postbyte |
| ptr_x | input | 16 | Pointer register X |
| ptr_y | input | 16 | Pointer register Y |
| ptr_u | input | 16 | Pointer register U |
| ptr_s | input | 16 | Pointer register S |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| pc_next | input | 16 | Address of the byte after the postbyte |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_valid | input | 1 | Read data present; takes the current request |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Final effective address |
| wb_en | output | 1 | Pointer write-back required |
| wb_sel | output | 2 | Pointer to write back (R2 coding) |
| wb_val | output | 16 | Write-back value |
| extra_bytes | output | 2 | Offset bytes consumed after the postbyte |
| extra_cycles | output | 4 | Extra cycle cost of the form |
| illegal | output | 1 | Meaningless encoding |

## Verification
A wrong decode shows at the very next `done` as a wrong cycle count, byte count or illegal flag. It also shows earlier, as a memory request that should not exist, or a missing one, within two cycles of `start`. A wrong offset-byte order or base selection shows only in `ea`, so each form is checked with values whose bytes differ and whose sums wrap. A fetch unit that drops or reorders a byte under wait states would either stall until the request watchdog fires or return a pointer with its halves swapped, which the indirect tests at several wait counts expose.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
   localparam int CYC_W = 4;

   typedef enum logic [3:0] {
      K_NONE, K_SHORT, K_ACCA, K_ACCB, K_ACCD, K_BYTE, K_WORD,
      K_INC1, K_INC2, K_DEC1, K_DEC2
   } ofs_kind_e;

   typedef struct packed {
      logic             illegal;
      logic             indirect;
      logic [1:0]       nbytes;
      logic [CYC_W-1:0] cycles;
      ofs_kind_e        kind;
      logic             pc_base;
      logic             abs_base;
      logic [1:0]       rsel;
   } idx_dec_t;
endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
   import idx_ea_pkg::*;
(
   input  logic [7:0] pb,
   output idx_dec_t   dec
);
   logic ind;
   assign ind = pb[4];

   always_comb begin
      dec      = '0;
      dec.kind = K_NONE;
      dec.rsel = pb[6:5];
      if (!pb[7]) begin
         dec.kind   = K_SHORT;
         dec.cycles = CYC_W'(1);
      end else begin
         dec.indirect = ind;
         case (pb[3:0])
            4'b0000: begin dec.kind = K_INC1; dec.cycles = CYC_W'(2); dec.illegal = ind; end
            4'b0001: begin dec.kind = K_INC2; dec.cycles = ind ? CYC_W'(6) : CYC_W'(3); end
            4'b0010: begin dec.kind = K_DEC1; dec.cycles = CYC_W'(2); dec.illegal = ind; end
            4'b0011: begin dec.kind = K_DEC2; dec.cycles = ind ? CYC_W'(6) : CYC_W'(3); end
            4'b0100: begin dec.kind = K_NONE; dec.cycles = ind ? CYC_W'(3) : CYC_W'(0); end
            4'b0101: begin dec.kind = K_ACCB; dec.cycles = ind ? CYC_W'(4) : CYC_W'(1); end
            4'b0110: begin dec.kind = K_ACCA; dec.cycles = ind ? CYC_W'(4) : CYC_W'(1); end
            4'b1000: begin
               dec.kind = K_BYTE; dec.nbytes = 2'd1;
               dec.cycles = ind ? CYC_W'(4) : CYC_W'(1);
            end
            4'b1001: begin
               dec.kind = K_WORD; dec.nbytes = 2'd2;
               dec.cycles = ind ? CYC_W'(7) : CYC_W'(4);
            end
            4'b1011: begin dec.kind = K_ACCD; dec.cycles = ind ? CYC_W'(7) : CYC_W'(4); end
            4'b1100: begin
               dec.kind = K_BYTE; dec.nbytes = 2'd1; dec.pc_base = 1'b1;
               dec.cycles = ind ? CYC_W'(4) : CYC_W'(1);
            end
            4'b1101: begin
               dec.kind = K_WORD; dec.nbytes = 2'd2; dec.pc_base = 1'b1;
               dec.cycles = ind ? CYC_W'(8) : CYC_W'(5);
            end
            4'b1111: begin
               dec.kind = K_WORD; dec.nbytes = 2'd2; dec.abs_base = 1'b1;
               dec.cycles = CYC_W'(5); dec.illegal = !ind;
            end
            default: dec.illegal = 1'b1;
         endcase
      end
      if (dec.illegal) begin
         dec.indirect = 1'b0;
         dec.nbytes   = 2'd0;
         dec.cycles   = '0;
         dec.kind     = K_NONE;
         dec.pc_base  = 1'b0;
         dec.abs_base = 1'b0;
      end
   end
endmodule

// File: rtl/idx_ea_addr.sv
module idx_ea_addr
   import idx_ea_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int NPTR = 4
) (
   input  idx_dec_t           dec,
   input  logic [4:0]         short_ofs,
   input  logic [NPTR*AW-1:0] ptrs,
   input  logic [DW-1:0]      acc_a,
   input  logic [DW-1:0]      acc_b,
   input  logic [AW-1:0]      off_word,
   input  logic [AW-1:0]      pc_ref,
   output logic [AW-1:0]      addr,
   output logic [AW-1:0]      wb_val,
   output logic               wb_en
);
   localparam int RSW = $clog2(NPTR);

   logic [AW-1:0] sel_terms [NPTR];
   logic [AW-1:0] reg_val, base, offset;

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr_mux
      assign sel_terms[g] = (RSW'(dec.rsel) == RSW'(g)) ? ptrs[g*AW +: AW] : '0;
   end

   always_comb begin
      reg_val = '0;
      for (int i = 0; i < NPTR; i++) reg_val = reg_val | sel_terms[i];
   end

   always_comb begin
      if (dec.abs_base)     base = '0;
      else if (dec.pc_base) base = pc_ref + AW'(dec.nbytes);
      else                  base = reg_val;
   end

   always_comb begin
      case (dec.kind)
         K_SHORT: offset = {{(AW-5){short_ofs[4]}}, short_ofs};
         K_ACCA:  offset = {{(AW-DW){acc_a[DW-1]}}, acc_a};
         K_ACCB:  offset = {{(AW-DW){acc_b[DW-1]}}, acc_b};
         K_ACCD:  offset = AW'({acc_a, acc_b});
         K_BYTE:  offset = {{(AW-DW){off_word[DW-1]}}, off_word[DW-1:0]};
         K_WORD:  offset = off_word;
         K_DEC1:  offset = '1;
         K_DEC2:  offset = {{(AW-1){1'b1}}, 1'b0};
         default: offset = '0;
      endcase
   end

   assign addr = base + offset;

   always_comb begin
      wb_en  = 1'b1;
      case (dec.kind)
         K_INC1:        wb_val = base + AW'(1);
         K_INC2:        wb_val = base + AW'(2);
         K_DEC1, K_DEC2: wb_val = addr;
         default: begin wb_val = '0; wb_en = 1'b0; end
      endcase
   end
endmodule

// File: rtl/idx_ea_fetch.sv
module idx_ea_fetch #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] base,
   input  logic [1:0]    count,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_valid,
   input  logic [DW-1:0] mem_rdata,
   output logic          fin,
   output logic [AW-1:0] word
);
   logic          busy;
   logic [1:0]    left;
   logic [AW-1:0] addr_q, acc_q;
   logic          take;

   assign take     = busy && mem_valid;
   assign mem_req  = busy;
   assign mem_addr = addr_q;
   assign word     = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         left   <= '0;
         addr_q <= '0;
         acc_q  <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= take && (left == 2'd1);
         if (go) begin
            busy   <= (count != 2'd0);
            left   <= count;
            addr_q <= base;
            acc_q  <= '0;
         end else if (take) begin
            acc_q  <= {acc_q[AW-DW-1:0], mem_rdata};
            addr_q <= addr_q + AW'(1);
            left   <= left - 2'd1;
            if (left == 2'd1) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
   import idx_ea_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NPTR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        postbyte,
   input  logic [2*DW-1:0]   ptr_x,
   input  logic [2*DW-1:0]   ptr_y,
   input  logic [2*DW-1:0]   ptr_u,
   input  logic [2*DW-1:0]   ptr_s,
   input  logic [DW-1:0]     acc_a,
   input  logic [DW-1:0]     acc_b,
   input  logic [2*DW-1:0]   pc_next,
   output logic              mem_req,
   output logic [2*DW-1:0]   mem_addr,
   input  logic              mem_valid,
   input  logic [DW-1:0]     mem_rdata,
   output logic              done,
   output logic [2*DW-1:0]   ea,
   output logic              wb_en,
   output logic [1:0]        wb_sel,
   output logic [2*DW-1:0]   wb_val,
   output logic [1:0]        extra_bytes,
   output logic [CYC_W-1:0]  extra_cycles,
   output logic              illegal
);
   localparam int AW = 2 * DW;

   if (DW != 8) begin : g_bad_dw
      $error("idx_ea_gen: DW must be 8");
   end
   if (NPTR != 4) begin : g_bad_nptr
      $error("idx_ea_gen: NPTR must be 4 to match the 2-bit register field");
   end

   typedef enum logic [2:0] {S_IDLE, S_DEC, S_OFS, S_ADDR, S_IND, S_FIN} st_e;
   st_e state;

   logic [7:0]         pb_q;
   logic [NPTR*AW-1:0] ptrs_q;
   logic [DW-1:0]      a_q, b_q;
   logic [AW-1:0]      pc_q, off_q;
   idx_dec_t           dec;
   logic [AW-1:0]      calc_addr, calc_wb;
   logic               calc_wb_en;
   logic               f_go, f_fin;
   logic [AW-1:0]      f_base, f_word;
   logic [1:0]         f_cnt;

   logic [AW-1:0]      ea_q, wb_val_q;
   logic               wb_en_q, ill_q;
   logic [1:0]         wb_sel_q, bytes_q;
   logic [CYC_W-1:0]   cyc_q;

   idx_ea_decode u_dec (.pb(pb_q), .dec(dec));

   idx_ea_addr #(.AW(AW), .DW(DW), .NPTR(NPTR)) u_addr (
      .dec(dec), .short_ofs(pb_q[4:0]), .ptrs(ptrs_q),
      .acc_a(a_q), .acc_b(b_q), .off_word(off_q), .pc_ref(pc_q),
      .addr(calc_addr), .wb_val(calc_wb), .wb_en(calc_wb_en)
   );

   assign f_go   = ((state == S_DEC) && !dec.illegal && (dec.nbytes != 2'd0))
                || ((state == S_ADDR) && dec.indirect);
   assign f_base = (state == S_ADDR) ? calc_addr : pc_q;
   assign f_cnt  = (state == S_ADDR) ? 2'd2 : dec.nbytes;

   idx_ea_fetch #(.AW(AW), .DW(DW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(f_go), .base(f_base), .count(f_cnt),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .fin(f_fin), .word(f_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         pb_q     <= '0;
         ptrs_q   <= '0;
         a_q      <= '0;
         b_q      <= '0;
         pc_q     <= '0;
         off_q    <= '0;
         ea_q     <= '0;
         wb_val_q <= '0;
         wb_en_q  <= 1'b0;
         wb_sel_q <= '0;
         ill_q    <= 1'b0;
         bytes_q  <= '0;
         cyc_q    <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               pb_q     <= postbyte;
               ptrs_q   <= {ptr_s, ptr_u, ptr_y, ptr_x};
               a_q      <= acc_a;
               b_q      <= acc_b;
               pc_q     <= pc_next;
               off_q    <= '0;
               ea_q     <= '0;
               wb_en_q  <= 1'b0;
               wb_val_q <= '0;
               ill_q    <= 1'b0;
               state    <= S_DEC;
            end
            S_DEC: begin
               bytes_q  <= dec.nbytes;
               cyc_q    <= dec.cycles;
               ill_q    <= dec.illegal;
               wb_sel_q <= dec.rsel;
               if (dec.illegal)              state <= S_FIN;
               else if (dec.nbytes != 2'd0)  state <= S_OFS;
               else                          state <= S_ADDR;
            end
            S_OFS: if (f_fin) begin
               off_q <= f_word;
               state <= S_ADDR;
            end
            S_ADDR: begin
               wb_en_q  <= calc_wb_en;
               wb_val_q <= calc_wb;
               if (dec.indirect) state <= S_IND;
               else begin
                  ea_q  <= calc_addr;
                  state <= S_FIN;
               end
            end
            S_IND: if (f_fin) begin
               ea_q  <= f_word;
               state <= S_FIN;
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign done         = (state == S_FIN);
   assign ea           = ea_q;
   assign wb_en        = wb_en_q;
   assign wb_sel       = wb_sel_q;
   assign wb_val       = wb_val_q;
   assign extra_bytes  = bytes_q;
   assign extra_cycles = cyc_q;
   assign illegal      = ill_q;
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic [7:0]  postbyte,
   input logic        mem_req,
   input logic [15:0] mem_addr,
   input logic        mem_valid,
   input logic        done,
   input logic        illegal,
   input logic        wb_en,
   input logic [1:0]  extra_bytes,
   input logic [3:0]  extra_cycles
);
   logic       busy, seen;
   logic [7:0] pb_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         seen <= 1'b0;
         pb_c <= '0;
      end else begin
         if (start && !busy) begin
            busy <= 1'b1;
            pb_c <= postbyte;
         end else if (done) begin
            busy <= 1'b0;
         end
         if (start && !busy) seen <= 1'b0;
         else if (busy && mem_req) seen <= 1'b1;
      end
   end

   // R11: a pending read keeps its request and address
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   // R11: completion strobe lasts one cycle
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: illegal encodings touch neither memory nor registers
   a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |-> (!seen && !wb_en && extra_bytes == 2'd0 && extra_cycles == 4'd0));

   // R1: short inline form costs one cycle, no bytes, no write-back
   a_r1_short_form: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pb_c[7]) |-> (!illegal && !wb_en && !seen && extra_bytes == 2'd0 && extra_cycles == 4'd1));

   // R3: only the increment/decrement codes write back
   a_r3_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
      (done && wb_en) |-> (pb_c[7] && pb_c[3:2] == 2'b00));

   // R9: no form costs more than eight extra cycles
   a_r9_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal) |-> (extra_cycles <= 4'd8));
endmodule

bind idx_ea_gen idx_ea_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
   .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
   .done(done), .illegal(illegal), .wb_en(wb_en),
   .extra_bytes(extra_bytes), .extra_cycles(extra_cycles)
);

// File: tb/idx_ea_gen_bench.sv
module idx_ea_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  postbyte = '0;
   logic [15:0] ptr_x = '0, ptr_y = '0, ptr_u = '0, ptr_s = '0, pc_next = '0;
   logic [7:0]  acc_a = '0, acc_b = '0;
   logic        mem_req, mem_valid = 1'b0;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        done, wb_en, illegal;
   logic [1:0]  wb_sel, extra_bytes;
   logic [15:0] ea, wb_val;
   logic [3:0]  extra_cycles;

   int checks = 0, failures = 0;
   int wait_n = 0, wcnt = 0, req_cycles = 0, addr_viol = 0;
   logic        prev_req = 1'b0;
   logic [15:0] prev_addr = '0;

   always #5 clk = ~clk;

   idx_ea_gen u_idx_ea_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
      .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_u(ptr_u), .ptr_s(ptr_s),
      .acc_a(acc_a), .acc_b(acc_b), .pc_next(pc_next),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .done(done), .ea(ea), .wb_en(wb_en),
      .wb_sel(wb_sel), .wb_val(wb_val), .extra_bytes(extra_bytes),
      .extra_cycles(extra_cycles), .illegal(illegal)
   );

   function automatic logic [7:0] mb(input logic [15:0] ad);
      return ad[7:0] ^ ad[15:8] ^ 8'h5A;
   endfunction
   function automatic logic [15:0] mw(input logic [15:0] ad);
      return {mb(ad), mb(ad + 16'd1)};
   endfunction
   function automatic logic [15:0] sx8(input logic [7:0] v);
      return {{8{v[7]}}, v};
   endfunction

   // memory responder with programmable wait states
   always @(negedge clk) begin
      if (mem_req) begin
         req_cycles++;
         if (prev_req && !mem_valid && mem_addr != prev_addr) addr_viol++;
         if (wcnt >= wait_n) begin
            mem_valid = 1'b1;
            mem_rdata = mb(mem_addr);
            wcnt = 0;
         end else begin
            mem_valid = 1'b0;
            wcnt++;
         end
      end else begin
         mem_valid = 1'b0;
         wcnt = 0;
      end
      prev_req  = mem_req;
      prev_addr = mem_addr;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [7:0] pb);
      int n;
      @(negedge clk);
      postbyte = pb;
      start = 1'b1;
      req_cycles = 0;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 300) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL R11 request timeout actual=0 expected=1");
      end
   endtask

   task automatic expect_out(input string req, input logic [15:0] e_ea,
                             input logic e_wb, input logic [15:0] e_wbv,
                             input logic [1:0] e_by, input logic [3:0] e_cy);
      chk(req, "ea", ea, e_ea);
      chk(req, "wb_en", wb_en, e_wb);
      if (e_wb) chk(req, "wb_val", wb_val, e_wbv);
      chk(req, "extra_bytes", extra_bytes, e_by);
      chk("R9", "extra_cycles", extra_cycles, e_cy);
      chk("R10", "illegal", illegal, 1'b0);
   endtask

   task automatic t_reset();
      chk("R11", "done after reset", done, 1'b0);
      chk("R11", "mem_req after reset", mem_req, 1'b0);
   endtask

   task automatic t_short();
      logic [15:0] regs [4];
      regs[0] = 16'h1000; regs[1] = 16'h2345; regs[2] = 16'hFFF8; regs[3] = 16'h0004;
      ptr_x = regs[0]; ptr_y = regs[1]; ptr_u = regs[2]; ptr_s = regs[3];
      run(8'b0_01_10011);                 // R1: Y - 13
      expect_out("R1", 16'h2345 - 16'd13, 1'b0, 16'h0, 2'd0, 4'd1);
      chk("R1", "no memory reads", req_cycles, 0);
      for (int r = 0; r < 4; r++) begin   // R2: register field, +15
         run({1'b0, 2'(r), 5'h0F});
         expect_out("R2", regs[r] + 16'd15, 1'b0, 16'h0, 2'd0, 4'd1);
      end
   endtask

   task automatic t_autoinc();
      ptr_x = 16'hFFFF; ptr_y = 16'h0001; ptr_u = 16'h3000; ptr_s = 16'h2000;
      run(8'b1_00_0_0000);                // R3 X+ wraps
      expect_out("R3", 16'hFFFF, 1'b1, 16'h0000, 2'd0, 4'd2);
      chk("R2", "wb_sel X", wb_sel, 2'd0);
      run(8'b1_11_0_0001);                // R3 S++
      expect_out("R3", 16'h2000, 1'b1, 16'h2002, 2'd0, 4'd3);
      chk("R2", "wb_sel S", wb_sel, 2'd3);
      run(8'b1_10_0_0010);                // R3 -U
      expect_out("R3", 16'h2FFF, 1'b1, 16'h2FFF, 2'd0, 4'd2);
      run(8'b1_01_0_0011);                // R3 --Y wraps
      expect_out("R3", 16'hFFFF, 1'b1, 16'hFFFF, 2'd0, 4'd3);
      chk("R2", "wb_sel Y", wb_sel, 2'd1);
   endtask

   task automatic t_acc();
      ptr_x = 16'h4000; ptr_u = 16'h0010;
      acc_a = 8'h80; acc_b = 8'h7F;
      run(8'b1_00_0_0110);                // R4 A offset, negative
      expect_out("R4", 16'h4000 - 16'd128, 1'b0, 16'h0, 2'd0, 4'd1);
      run(8'b1_00_0_0101);                // R4 B offset
      expect_out("R4", 16'h407F, 1'b0, 16'h0, 2'd0, 4'd1);
      run(8'b1_10_0_1011);                // R4 D offset = A:B
      expect_out("R4", 16'h0010 + 16'h807F, 1'b0, 16'h0, 2'd0, 4'd4);
      run(8'b1_00_0_0100);                // R9 zero offset
      expect_out("R9", 16'h4000, 1'b0, 16'h0, 2'd0, 4'd0);
   endtask

   task automatic t_const();
      wait_n = 2;
      ptr_x = 16'hFF00; pc_next = 16'h12C4;
      run(8'b1_00_0_1000);                // R5 8-bit
      expect_out("R5", ptr_x + sx8(mb(16'h12C4)), 1'b0, 16'h0, 2'd1, 4'd1);
      run(8'b1_00_0_1001);                // R5 16-bit, wraps
      expect_out("R5", ptr_x + mw(16'h12C4), 1'b0, 16'h0, 2'd2, 4'd4);
      wait_n = 0;
   endtask

   task automatic t_pcrel();
      pc_next = 16'h7F10; ptr_x = 16'h0; ptr_s = 16'hAAAA;
      run(8'b1_00_0_1100);                // R6 PC + 8
      expect_out("R6", 16'h7F11 + sx8(mb(16'h7F10)), 1'b0, 16'h0, 2'd1, 4'd1);
      run(8'b1_11_0_1100);                // R6 field ignored
      expect_out("R6", 16'h7F11 + sx8(mb(16'h7F10)), 1'b0, 16'h0, 2'd1, 4'd1);
      run(8'b1_01_0_1101);                // R6 PC + 16
      expect_out("R6", 16'h7F12 + mw(16'h7F10), 1'b0, 16'h0, 2'd2, 4'd5);
   endtask

   task automatic t_indirect();
      wait_n = 1;
      ptr_x = 16'h0100; ptr_y = 16'hF000; ptr_u = 16'h0200; ptr_s = 16'h0802;
      acc_a = 8'h01; acc_b = 8'hFE; pc_next = 16'h3456;
      run(8'b1_00_1_0100);                // R7 [,X]
      expect_out("R7", mw(16'h0100), 1'b0, 16'h0, 2'd0, 4'd3);
      run(8'b1_01_1_1001);                // R7 [n16,Y]
      expect_out("R7", mw(16'hF000 + mw(16'h3456)), 1'b0, 16'h0, 2'd2, 4'd7);
      run(8'b1_11_1_0011);                // R7 [,--S] with write-back
      expect_out("R7", mw(16'h0800), 1'b1, 16'h0800, 2'd0, 4'd6);
      run(8'b1_11_1_0001);                // R7 [,S++]
      expect_out("R7", mw(16'h0802), 1'b1, 16'h0804, 2'd0, 4'd6);
      run(8'b1_10_1_1011);                // R7 [D,U]
      expect_out("R7", mw(16'h0200 + 16'h01FE), 1'b0, 16'h0, 2'd0, 4'd7);
      run(8'b1_00_1_0101);                // R7 [B,X]
      expect_out("R7", mw(16'h0100 + 16'hFFFE), 1'b0, 16'h0, 2'd0, 4'd4);
      run(8'b1_00_1_1000);                // R7 [n8,X]
      expect_out("R7", mw(16'h0100 + sx8(mb(16'h3456))), 1'b0, 16'h0, 2'd1, 4'd4);
      run(8'b1_00_1_1100);                // R7 [n8,PC]
      expect_out("R7", mw(16'h3457 + sx8(mb(16'h3456))), 1'b0, 16'h0, 2'd1, 4'd4);
      run(8'b1_00_1_1101);                // R7 [n16,PC]
      expect_out("R7", mw(16'h3458 + mw(16'h3456)), 1'b0, 16'h0, 2'd2, 4'd8);
      wait_n = 0;
   endtask

   task automatic t_extind();
      pc_next = 16'hC0DE;
      run(8'b1_01_1_1111);                // R8
      expect_out("R8", mw(mw(16'hC0DE)), 1'b0, 16'h0, 2'd2, 4'd5);
   endtask

   task automatic t_illegal();
      logic [7:0] bad [6];
      bad[0] = 8'h87; bad[1] = 8'h9A; bad[2] = 8'hEE;
      bad[3] = 8'h90; bad[4] = 8'hB2; bad[5] = 8'h8F;
      for (int k = 0; k < 6; k++) begin
         run(bad[k]);
         chk("R10", "illegal flag", illegal, 1'b1);
         chk("R10", "no write-back", wb_en, 1'b0);
         chk("R10", "no memory request", req_cycles, 0);
         chk("R10", "bytes/cycles zero", {extra_bytes, extra_cycles}, 6'd0);
      end
   endtask

   task automatic t_handshake();
      wait_n = 3;
      ptr_y = 16'h1234; pc_next = 16'h0FFF;
      run(8'b1_01_1_1001);
      expect_out("R11", mw(16'h1234 + mw(16'h0FFF)), 1'b0, 16'h0, 2'd2, 4'd7);
      @(negedge clk);
      chk("R11", "done one cycle", done, 1'b0);
      chk("R11", "address held while waiting", addr_viol, 0);
      wait_n = 0;
   endtask

   initial begin
      int wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short();
      t_autoinc();
      t_acc();
      t_const();
      t_pcrel();
      t_indirect();
      t_extind();
      t_illegal();
      t_handshake();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule